// File: doc/BRIEF.md
# Three-Head Intersection Signal Controller

This block sequences three signal heads at a junction: the east-west through movement, the east-west turning arrow and the north-south movement. Each head takes one of three colours, and the controller serves the movements one at a time. A vehicle sensor for each movement tells the controller where demand exists. A green is held for a guaranteed minimum. After the minimum it ends early when its own lane empties while another lane waits. It is cut off at a hard ceiling when its own lane stays busy but another lane is waiting. With no competing demand a green holds without limit. Every green passes through a fixed yellow interval before that head returns to red.

The next movement to be served is chosen by rotating priority. The search starts with the movement after the one just served and wraps around, so a busy lane cannot starve the others. When no lane is requesting at the end of a yellow, all heads rest on red until a sensor rises. There is no data stream at this block's edge. The sensors and lamp codes are plain level signals, so no valid/ready handshake applies.

Top module: `junction_ctrl`

## Requirements
- R1: Each lamp output is a 2-bit code with red = 0, yellow = 1 and green = 2. The outputs are, in movement order, `lamp_ew_thru` (index 0), `lamp_ew_turn` (index 1) and `lamp_ns` (index 2).
- R2: At any time at most one of the three heads shows a colour other than red.
- R3: Once a head turns green it stays green for at least MIN_GREEN (default 5) consecutive cycles.
- R4: If the served lane's own sensor stays active and another lane is requesting, the green ends after exactly MAX_GREEN (default 10) cycles counted from its first green cycle. If the green is already older than that when a competing request appears, it ends at the next clock edge.
- R5: After the minimum, a green ends at the next clock edge once its own sensor is low while some other lane's sensor is high.
- R6: While no other lane's sensor is high, the current green holds indefinitely, whatever its own sensor does.
- R7: Every green is followed on the same head by exactly YELLOW_LEN (default 2) cycles of yellow, then that head shows red.
- R8: The next green goes to the first active sensor in the cyclic order 0, 1, 2, starting with the index after the movement last served. The movement last served is considered only after the other two.
- R9: Reset forces all heads to red. All heads stay red while no sensor is active. All heads return to red after a yellow if no sensor is then active.
- R10: From the all-red rest state, a green appears on the chosen head at the first clock edge that samples an active sensor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sense_ew_thru | input | 1 | Vehicle present, east-west through lane |
| sense_ew_turn | input | 1 | Vehicle present, east-west turning lane |
| sense_ns | input | 1 | Vehicle present, north-south lanes |
| lamp_ew_thru | output | 2 | Colour code, east-west through head |
| lamp_ew_turn | output | 2 | Colour code, east-west turning arrow |
| lamp_ns | output | 2 | Colour code, north-south head |

## Verification
The hardest conditions to reach from the ports are the two ways a green can end once the minimum has passed. One is the hard ceiling, which needs the served lane held busy while a rival request is raised inside the window. The other is the early release at an intermediate age. The stimulus reaches both by raising and dropping sensors at counted cycles after a green is first seen. The served lane's sensor is held high for the ceiling case and dropped at a chosen age for the early-release case. Rotation is exercised by raising two rival sensors together at the end of a phase, so that the winner depends only on the movement just served.

// File: rtl/jc_pkg.sv
package jc_pkg;
  typedef enum logic [1:0] {
    LAMP_RED    = 2'd0,
    LAMP_YELLOW = 2'd1,
    LAMP_GREEN  = 2'd2
  } lamp_t;

  typedef enum logic [1:0] {
    PH_ALLRED = 2'd0,
    PH_GO     = 2'd1,
    PH_CLEAR  = 2'd2
  } phase_t;

  localparam int N_MOV = 3;
  localparam int IDX_W = 2;
endpackage

// File: rtl/jc_rr_pick.sv
module jc_rr_pick #(
  parameter int N     = 3,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req,
  input  logic [IDX_W-1:0] last,
  output logic             found,
  output logic [IDX_W-1:0] grant
);
  logic [IDX_W-1:0] cand [1:N];

  for (genvar k = 1; k <= N; k++) begin : g_cand
    localparam int KK = k;
    always_comb begin
      int s;
      s = int'(last) + KK;
      if (s >= N) s = s - N;
      cand[k] = IDX_W'(s);
    end
  end

  always_comb begin
    found = 1'b0;
    grant = '0;
    for (int k = N; k >= 1; k--) begin
      if (req[cand[k]]) begin
        found = 1'b1;
        grant = cand[k];
      end
    end
  end
endmodule

// File: rtl/jc_age_counter.sv
module jc_age_counter #(
  parameter int LIMIT = 9,
  parameter int W     = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] age
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            age <= '0;
    else if (clr)                          age <= '0;
    else if (en && age != W'(LIMIT))       age <= age + 1'b1;
  end
endmodule

// File: rtl/jc_head_decode.sv
module jc_head_decode
  import jc_pkg::*;
#(
  parameter int N     = 3,
  parameter int IDX_W = 2
) (
  input  phase_t           phase,
  input  logic [IDX_W-1:0] cur,
  output lamp_t            lamp [N]
);
  for (genvar h = 0; h < N; h++) begin : g_head
    always_comb begin
      lamp[h] = LAMP_RED;
      if (cur == IDX_W'(h)) begin
        if (phase == PH_GO)         lamp[h] = LAMP_GREEN;
        else if (phase == PH_CLEAR) lamp[h] = LAMP_YELLOW;
      end
    end
  end
endmodule

// File: rtl/junction_ctrl.sv
module junction_ctrl
  import jc_pkg::*;
#(
  parameter int MIN_GREEN  = 5,
  parameter int MAX_GREEN  = 10,
  parameter int YELLOW_LEN = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sense_ew_thru,
  input  logic       sense_ew_turn,
  input  logic       sense_ns,
  output logic [1:0] lamp_ew_thru,
  output logic [1:0] lamp_ew_turn,
  output logic [1:0] lamp_ns
);
  localparam int G_W = $clog2(MAX_GREEN + 1);
  localparam int Y_W = $clog2(YELLOW_LEN + 1);

  phase_t           phase;
  logic [IDX_W-1:0] cur;
  logic [N_MOV-1:0] req;
  logic [N_MOV-1:0] cur_mask;
  logic             conflict, own;
  logic             end_green, end_yellow;
  logic             pick_ok;
  logic [IDX_W-1:0] pick_idx;
  logic [G_W-1:0]   g_age;
  logic [Y_W-1:0]   y_age;
  lamp_t            lamp [N_MOV];

  assign req = {sense_ns, sense_ew_turn, sense_ew_thru};

  always_comb begin
    cur_mask = '0;
    cur_mask[cur] = 1'b1;
  end

  assign conflict = |(req & ~cur_mask);
  assign own      = req[cur];

  jc_age_counter #(.LIMIT(MAX_GREEN - 1), .W(G_W)) u_green_age (
    .clk(clk), .rst_n(rst_n),
    .clr(phase != PH_GO), .en(phase == PH_GO), .age(g_age)
  );

  jc_age_counter #(.LIMIT(YELLOW_LEN - 1), .W(Y_W)) u_yellow_age (
    .clk(clk), .rst_n(rst_n),
    .clr(phase != PH_CLEAR), .en(phase == PH_CLEAR), .age(y_age)
  );

  jc_rr_pick #(.N(N_MOV), .IDX_W(IDX_W)) u_pick (
    .req(req), .last(cur), .found(pick_ok), .grant(pick_idx)
  );

  assign end_green  = conflict && (g_age >= G_W'(MIN_GREEN - 1)) &&
                      (!own || g_age == G_W'(MAX_GREEN - 1));
  assign end_yellow = (y_age == Y_W'(YELLOW_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_ALLRED;
      cur   <= IDX_W'(N_MOV - 1);
    end else begin
      unique case (phase)
        PH_ALLRED: if (pick_ok) begin
          phase <= PH_GO;
          cur   <= pick_idx;
        end
        PH_GO: if (end_green) phase <= PH_CLEAR;
        PH_CLEAR: if (end_yellow) begin
          if (pick_ok) begin
            phase <= PH_GO;
            cur   <= pick_idx;
          end else begin
            phase <= PH_ALLRED;
          end
        end
        default: phase <= PH_ALLRED;
      endcase
    end
  end

  jc_head_decode #(.N(N_MOV), .IDX_W(IDX_W)) u_decode (
    .phase(phase), .cur(cur), .lamp(lamp)
  );

  assign lamp_ew_thru = lamp[0];
  assign lamp_ew_turn = lamp[1];
  assign lamp_ns      = lamp[2];

  // Safety: never two heads away from red.
  assert_single_head_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({lamp_ew_thru != 2'd0, lamp_ew_turn != 2'd0, lamp_ns != 2'd0}) <= 1);

  assert_min_green_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CLEAR && $past(phase) == PH_GO) |-> $past(g_age) >= G_W'(MIN_GREEN - 1));

  assert_max_cut_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_GO && conflict && g_age == G_W'(MAX_GREEN - 1)) |=> phase == PH_CLEAR);

  assert_gap_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_GO && conflict && !own && g_age >= G_W'(MIN_GREEN - 1)) |=> phase == PH_CLEAR);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_GO && !conflict) |=> (phase == PH_GO && $stable(cur)));

  for (genvar h = 0; h < N_MOV; h++) begin : g_seq_chk
    assert_yellow_after_green_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(lamp[h] == LAMP_GREEN) && lamp[h] != LAMP_GREEN |-> lamp[h] == LAMP_YELLOW);
  end
endmodule

// File: tb/junction_ctrl_tb.sv
module junction_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_thru = 1'b0, s_turn = 1'b0, s_ns = 1'b0;
  logic [1:0] l_thru, l_turn, l_ns;
  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [5:0] RRR = 6'b00_00_00;
  localparam logic [5:0] GRR = 6'b10_00_00;
  localparam logic [5:0] YRR = 6'b01_00_00;
  localparam logic [5:0] RGR = 6'b00_10_00;
  localparam logic [5:0] RRG = 6'b00_00_10;

  always #10 clk = ~clk;

  junction_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .sense_ew_thru(s_thru), .sense_ew_turn(s_turn), .sense_ns(s_ns),
    .lamp_ew_thru(l_thru), .lamp_ew_turn(l_turn), .lamp_ns(l_ns)
  );

  function automatic logic [1:0] head(input int idx);
    case (idx)
      0: return l_thru;
      1: return l_turn;
      default: return l_ns;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_heads(input logic [5:0] exp, input string tag);
    check({l_thru, l_turn, l_ns} == exp, tag, {l_thru, l_turn, l_ns}, exp);
  endtask

  // One clock; sample 1 ns after the edge and check the single-head rule (R2).
  task automatic step();
    int nz;
    @(posedge clk);
    #1;
    nz = int'(l_thru != 0) + int'(l_turn != 0) + int'(l_ns != 0);
    check(nz <= 1, "R2 single head", nz, 1);
  endtask

  // Count consecutive observations of colour col on head idx, starting now.
  task automatic run_len(input int idx, input logic [1:0] col, input int exp, input string tag);
    int cnt = 0;
    while (head(idx) == col && cnt < 200) begin
      cnt++;
      step();
    end
    check(cnt == exp, tag, cnt, exp);
  endtask

  task automatic t_reset_idle();
    rst_n = 1'b0;
    #5;
    check_heads(RRR, "R9 reset all red");
    step();
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      step();
      check_heads(RRR, "R9 idle all red");
    end
  endtask

  task automatic t_first_grant_hold();
    s_thru = 1'b1;
    step();
    check_heads(GRR, "R10 first green / R1 code");
    s_thru = 1'b0;
    for (int i = 0; i < 30; i++) begin
      step();
      check_heads(GRR, "R6 hold without rivals");
    end
    s_thru = 1'b1;
    s_ns = 1'b1;
    step();
    check_heads(YRR, "R4 aged green cut at once");
    run_len(0, 2'd1, 2, "R7 yellow length");
    check_heads(RRG, "R8 turn lane skipped, ns served");
    s_thru = 1'b0;
  endtask

  task automatic t_max_green();
    s_turn = 1'b1;
    run_len(2, 2'd2, 10, "R4 max green with rival");
    run_len(2, 2'd1, 2, "R7 yellow after ns");
    check_heads(RGR, "R8 turn lane next");
  endtask

  task automatic t_min_green();
    s_turn = 1'b0;
    s_thru = 1'b1;
    s_ns = 1'b1;
    run_len(1, 2'd2, 5, "R3 minimum green");
    run_len(1, 2'd1, 2, "R7 yellow after turn");
    check_heads(RRG, "R8 ns beats thru after turn");
  endtask

  task automatic t_gap_out();
    int g = 1;
    for (int i = 0; i < 6; i++) begin
      step();
      if (l_ns == 2'd2) g++;
    end
    check(g == 7, "R5 green still held at age 6", g, 7);
    s_ns = 1'b0;
    step();
    check_heads(RRR | 6'b00_00_01, "R5 gap-out to yellow");
    run_len(2, 2'd1, 2, "R7 yellow after gap-out");
    check_heads(GRR, "R8 thru after ns");
  endtask

  task automatic t_return_idle();
    s_thru = 1'b0;
    s_turn = 1'b1;
    run_len(0, 2'd2, 5, "R3 minimum before turn rival");
    s_turn = 1'b0;
    run_len(0, 2'd1, 2, "R7 yellow then rest");
    check_heads(RRR, "R9 all red after yellow");
    for (int i = 0; i < 4; i++) begin
      step();
      check_heads(RRR, "R9 stays all red");
    end
    s_turn = 1'b1;
    s_ns = 1'b1;
    step();
    check_heads(RGR, "R10 grant from rest / R8 rotation");
    s_turn = 1'b0;
    s_ns = 1'b0;
    rst_n = 1'b0;
    #2;
    check_heads(RRR, "R9 reset mid-green");
    step();
    rst_n = 1'b1;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset_idle();
    t_first_grant_hold();
    t_max_green();
    t_min_green();
    t_gap_out();
    t_return_idle();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule